// File: doc/BRIEF.md
# Two-Level Masked Interrupt Aggregator

This block collects single-cycle event pulses from the rest of a device into a latched interrupt status register. Each status bit has a matching bit in an enable register. A request goes out on one interrupt line when the global enable is on and at least one status bit that is set is also enabled. Software clears a status bit by writing 1 to it. A status bit stays set until software clears it or a bus reset clears it.

DMA completion events go to a separate, smaller reason register. That register has its own enables and its own write-1-to-clear bits. The enabled reason bits are ORed into a single summary bit of the main status register. Software reads this summary bit in the main status register first, then reads the reason register to find the cause. A mode register holds the global enable and a choice of output form. In level form the line stays high while any enabled bit is pending. In pulse form the line gives a one-cycle pulse each time the gated request rises.

Software reaches the registers through a simple port: a 3-bit address, a write strobe, write data and combinational read data. Register addresses: 0 status, 1 enable, 2 DMA reason, 3 DMA reason enable, 4 mode.

Top module: `irq_aggregator`

## Requirements
- R1: After the asynchronous reset, every register reads 0 and `irq_o` is low.
- R2: A pulse on `evt_i[n]` (n below 24, n not 6) sets status bit n at the next clock edge. The bit stays set across later cycles until it is cleared.
- R3: Writing address 0 clears each status bit whose data bit is 1 and leaves bits written with 0 alone. When a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: Bits 31:24 of the status and enable registers always read 0. Writes to those bits have no effect.
- R5: Address 1 holds the enable bits 23:0 as plain read/write storage. Writing it does not change the status register.
- R6: Address 2 is the DMA reason register, with bit 0 = external end-of-transfer, bit 1 = internal end-of-transfer, bit 2 = transfer done. Pulses on `dma_evt_i[2:0]` set these bits, software writes 1 to clear them, and a set wins over a clear in the same cycle. Address 3 holds their enables in bits 2:0.
- R7: Status bit 6 is not stored. It reads 1 exactly when some reason bit and its enable are both 1. Writes to bit 6 and pulses on `evt_i[6]` have no effect.
- R8: A cycle with `bus_rst_i` high clears the status and reason registers at the next edge. This wins over events in the same cycle. Enables and mode are kept.
- R9: In level form (mode bit 1 = 0), `irq_o` is high when mode bit 0 (global enable) is 1 and any status bit with its enable bit set is 1. It follows register changes in the cycle after the edge that makes them. Clearing the global enable drops `irq_o` while the status bits are kept.
- R10: In pulse form (mode bit 1 = 1), `irq_o` is high for exactly the first cycle in which the gated request is high after a cycle in which it was low.
- R11: Address 4 holds the mode bits 1:0, and all its other bits read 0. Addresses 5 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_i | input | 24 | Event pulses, one per status bit |
| dma_evt_i | input | 3 | DMA reason event pulses |
| bus_rst_i | input | 1 | Bus reset, clears pending state |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit register, 24 live source bits, three reason bits and the summary at bit 6. With these values the bench reaches the reserved top byte, the one source bit that is not stored, and all three reason bits. Directed steps cover these cases: a set and a clear on the same bit, a bus reset together with events, turning off the global enable while bits are pending, and the rising-edge pulse. A seeded random phase then mixes writes to every address with events and rare bus resets. A behavioural model checks the output line and the read data on every cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT   = 3'd0,
    A_EN     = 3'd1,
    A_RSN    = 3'd2,
    A_RSN_EN = 3'd3,
    A_MODE   = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic pulse;
    logic gie;
  } mode_t;
endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         flush_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic d;
    logic ce;

    always_comb begin
      ce = flush_i | set_i[g] | clr_i[g];
      if (flush_i)       d = 1'b0;
      else if (set_i[g]) d = 1'b1;
      else               d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_q[g] <= 1'b0;
      else if (ce) q_q[g] <= d;
    end
  end

  assign q_o = q_q;

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0 && !flush_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && (clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));

  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (q_o == '0));
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_agg_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int SRC_W = 24,
  parameter int RSN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [SRC_W-1:0]  stat_i,
  input  logic [RSN_W-1:0]  rsn_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [SRC_W-1:0]  en_o,
  output logic [RSN_W-1:0]  ren_o,
  output mode_t             mode_o,
  output logic [SRC_W-1:0]  clr_stat_o,
  output logic [RSN_W-1:0]  clr_rsn_o
);
  logic [SRC_W-1:0] en_q, en_d;
  logic [RSN_W-1:0] ren_q, ren_d;
  mode_t            mode_q, mode_d;
  logic             wr_stat, wr_en, wr_rsn, wr_ren, wr_mode;
  logic             unused_hi;

  assign unused_hi = ^wdata_i[REG_W-1:SRC_W];

  always_comb begin
    wr_stat = we_i && (addr_i == A_STAT);
    wr_en   = we_i && (addr_i == A_EN);
    wr_rsn  = we_i && (addr_i == A_RSN);
    wr_ren  = we_i && (addr_i == A_RSN_EN);
    wr_mode = we_i && (addr_i == A_MODE);
    en_d    = wdata_i[SRC_W-1:0];
    ren_d   = wdata_i[RSN_W-1:0];
    mode_d  = mode_t'(wdata_i[1:0]);
    clr_stat_o = wr_stat ? wdata_i[SRC_W-1:0] : '0;
    clr_rsn_o  = wr_rsn  ? wdata_i[RSN_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      ren_q  <= '0;
      mode_q <= '0;
    end else begin
      if (wr_en)   en_q   <= en_d;
      if (wr_ren)  ren_q  <= ren_d;
      if (wr_mode) mode_q <= mode_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_STAT:   rdata_o[SRC_W-1:0] = stat_i;
      A_EN:     rdata_o[SRC_W-1:0] = en_q;
      A_RSN:    rdata_o[RSN_W-1:0] = rsn_i;
      A_RSN_EN: rdata_o[RSN_W-1:0] = ren_q;
      A_MODE:   rdata_o[1:0]       = mode_q;
      default:  rdata_o            = '0;
    endcase
  end

  assign en_o   = en_q;
  assign ren_o  = ren_q;
  assign mode_o = mode_q;

  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && addr_i == A_EN) |=> $stable(en_o));

  // R11
  mode_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == A_MODE) |=> (mode_o == $past(wdata_i[1:0])));
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int SRC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] stat_i,
  input  logic [SRC_W-1:0] en_i,
  input  logic             gie_i,
  input  logic             pulse_i,
  output logic             irq_o
);
  logic req;
  logic req_q;

  assign req = gie_i & (|(stat_i & en_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req;
  end

  assign irq_o = pulse_i ? (req & ~req_q) : req;

  // R9
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> !irq_o);

  // R10
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && irq_o) |=> (!irq_o || !pulse_i));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int SRC_W   = 24,
  parameter int RSN_W   = 3,
  parameter int DMA_IDX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [SRC_W-1:0]  evt_i,
  input  logic [RSN_W-1:0]  dma_evt_i,
  input  logic              bus_rst_i,
  output logic              irq_o
);
  localparam logic [SRC_W-1:0] SUM_BIT = SRC_W'(1) << DMA_IDX;

  logic [SRC_W-1:0] stat_q, stat_view, en, clr_stat;
  logic [RSN_W-1:0] rsn_q, ren, clr_rsn;
  logic             dma_any;
  mode_t            mode;

  irq_w1c_bank #(.W(SRC_W)) u_main (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (evt_i & ~SUM_BIT),
    .clr_i   (clr_stat & ~SUM_BIT),
    .flush_i (bus_rst_i),
    .q_o     (stat_q)
  );

  irq_w1c_bank #(.W(RSN_W)) u_reason (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (dma_evt_i),
    .clr_i   (clr_rsn),
    .flush_i (bus_rst_i),
    .q_o     (rsn_q)
  );

  assign dma_any   = |(rsn_q & ren);
  assign stat_view = (stat_q & ~SUM_BIT) | (dma_any ? SUM_BIT : '0);

  irq_ctrl_regs #(.REG_W(REG_W), .SRC_W(SRC_W), .RSN_W(RSN_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (reg_addr),
    .we_i       (reg_we),
    .wdata_i    (reg_wdata),
    .stat_i     (stat_view),
    .rsn_i      (rsn_q),
    .rdata_o    (reg_rdata),
    .en_o       (en),
    .ren_o      (ren),
    .mode_o     (mode),
    .clr_stat_o (clr_stat),
    .clr_rsn_o  (clr_rsn)
  );

  irq_out_stage #(.SRC_W(SRC_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_i  (stat_view),
    .en_i    (en),
    .gie_i   (mode.gie),
    .pulse_i (mode.pulse),
    .irq_o   (irq_o)
  );

  // R7
  dma_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_STAT) |-> (reg_rdata[DMA_IDX] == |(rsn_q & ren)));

  // R8
  keep_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_i && !reg_we) |=> $stable(en) && $stable(mode));
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [23:0] evt_i = '0;
  logic [2:0]  dma_evt_i = '0;
  logic        bus_rst_i = 1'b0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
    .dma_evt_i(dma_evt_i), .bus_rst_i(bus_rst_i), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  logic [31:0] m_stat, m_en;
  logic [2:0]  m_rsn, m_ren;
  logic        m_gie, m_pls, m_reqd;

  function automatic logic [31:0] m_view();
    logic [31:0] v;
    v = m_stat;
    v[6] = |(m_rsn & m_ren);
    return v;
  endfunction

  function automatic logic m_req();
    return m_gie && (|(m_view() & m_en));
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_view();
      3'd1: return m_en;
      3'd2: return {29'd0, m_rsn};
      3'd3: return {29'd0, m_ren};
      3'd4: return {30'd0, m_pls, m_gie};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = '0; m_en = '0; m_rsn = '0; m_ren = '0;
      m_gie = 1'b0; m_pls = 1'b0; m_reqd = 1'b0;
    end else begin
      logic [31:0] ns, cs;
      logic [2:0]  nr, cr;
      logic        rq;
      rq = m_req();
      cs = (reg_we && reg_addr == 3'd0) ? reg_wdata : 32'd0;
      cr = (reg_we && reg_addr == 3'd2) ? reg_wdata[2:0] : 3'd0;
      ns = bus_rst_i ? 32'd0 : ((m_stat & ~cs) | {8'd0, evt_i});
      ns[31:24] = 8'd0;
      ns[6] = 1'b0;
      nr = bus_rst_i ? 3'd0 : ((m_rsn & ~cr) | dma_evt_i);
      if (reg_we && reg_addr == 3'd1) m_en = reg_wdata & 32'h00FF_FFFF;
      if (reg_we && reg_addr == 3'd3) m_ren = reg_wdata[2:0];
      if (reg_we && reg_addr == 3'd4) begin
        m_gie = reg_wdata[0];
        m_pls = reg_wdata[1];
      end
      m_stat = ns;
      m_rsn = nr;
      m_reqd = rq;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic ei;
      ei = m_pls ? (m_req() && !m_reqd) : m_req();
      chk(m_pls ? "R10" : "R9", {31'd0, irq_o}, {31'd0, ei});
      case (reg_addr)
        3'd0: chk("R2", reg_rdata, m_read(reg_addr));
        3'd1: chk("R5", reg_rdata, m_read(reg_addr));
        3'd2, 3'd3: chk("R6", reg_rdata, m_read(reg_addr));
        default: chk("R11", reg_rdata, m_read(reg_addr));
      endcase
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); #1;
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic ev(input logic [23:0] e, input logic [2:0] de, input logic br);
    evt_i = e; dma_evt_i = de; bus_rst_i = br;
    @(negedge clk); #1;
    evt_i = '0; dma_evt_i = '0; bus_rst_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string req, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {31'd0, irq_o}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a);
      #1;
      chk("R1", reg_rdata, 32'd0);
    end
    reg_addr = 3'd0;
    @(negedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R2 events latch
    ev(24'h80_0009, 3'd0, 1'b0);
    rd(3'd0, "R2", 32'h0080_0009);
    @(negedge clk); #1;
    rd(3'd0, "R2", 32'h0080_0009);

    // R4 reserved enable bits, R9 gate off
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, "R4", 32'h00FF_FFFF);
    rd(3'd0, "R5", 32'h0080_0009);
    chk("R9", {31'd0, irq_o}, 32'd0);
    wr(3'd4, 32'h0000_0001);
    chk("R9", {31'd0, irq_o}, 32'd1);

    // R3 write-1-to-clear, reserved bits ignored
    wr(3'd0, 32'hFF80_0001);
    rd(3'd0, "R3", 32'h0000_0008);
    rd(3'd0, "R4", 32'h0000_0008);
    // R3 set wins over clear
    evt_i = 24'h8;
    wr(3'd0, 32'h0000_0008);
    evt_i = '0;
    rd(3'd0, "R3", 32'h0000_0008);
    wr(3'd0, 32'h0000_0008);
    rd(3'd0, "R3", 32'h0000_0000);
    chk("R9", {31'd0, irq_o}, 32'd0);

    // R7 summary bit is not a latch
    ev(24'h40, 3'd0, 1'b0);
    rd(3'd0, "R7", 32'h0000_0000);
    chk("R7", {31'd0, irq_o}, 32'd0);

    // R6 reason register and R7 summary
    ev(24'h0, 3'b010, 1'b0);
    rd(3'd2, "R6", 32'h0000_0002);
    rd(3'd0, "R7", 32'h0000_0000);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, "R6", 32'h0000_0007);
    rd(3'd0, "R7", 32'h0000_0040);
    chk("R7", {31'd0, irq_o}, 32'd1);
    wr(3'd0, 32'h0000_0040);
    rd(3'd0, "R7", 32'h0000_0040);

    // R9 global enable off keeps status
    wr(3'd4, 32'h0);
    chk("R9", {31'd0, irq_o}, 32'd0);
    rd(3'd2, "R9", 32'h0000_0002);
    rd(3'd0, "R9", 32'h0000_0040);

    // R6 clear reason, R10 pulse form
    wr(3'd2, 32'h0000_0002);
    rd(3'd2, "R6", 32'h0000_0000);
    wr(3'd4, 32'h0000_0003);
    chk("R10", {31'd0, irq_o}, 32'd0);
    ev(24'h0, 3'b001, 1'b0);
    chk("R10", {31'd0, irq_o}, 32'd1);
    @(negedge clk); #1;
    chk("R10", {31'd0, irq_o}, 32'd0);
    rd(3'd0, "R10", 32'h0000_0040);

    // R8 bus reset wins over events, keeps enables and mode
    ev(24'h4, 3'b100, 1'b1);
    rd(3'd0, "R8", 32'h0000_0000);
    rd(3'd2, "R8", 32'h0000_0000);
    rd(3'd1, "R8", 32'h00FF_FFFF);
    rd(3'd4, "R8", 32'h0000_0003);

    // R11 unmapped addresses and mode upper bits
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, "R11", 32'h0000_0000);
    rd(3'd7, "R11", 32'h0000_0000);
    rd(3'd1, "R11", 32'h00FF_FFFF);
    wr(3'd4, 32'hFFFF_FFFD);
    rd(3'd4, "R11", 32'h0000_0001);

    // random mix, model compared each cycle
    for (int i = 0; i < 2000; i++) begin
      int unsigned r;
      r = $urandom;
      reg_addr  = 3'(r % 8);
      reg_we    = (r[7:4] < 4'd5);
      reg_wdata = $urandom;
      evt_i     = ((r[11:8] < 4'd3) ? 24'($urandom) : 24'd0);
      dma_evt_i = ((r[15:12] < 4'd3) ? 3'($urandom) : 3'd0);
      bus_rst_i = (r[23:16] < 8'd4);
      @(negedge clk); #1;
    end
    reg_we = 1'b0; evt_i = '0; dma_evt_i = '0; bus_rst_i = 1'b0;
    @(negedge clk); #1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule